// File: doc/BRIEF.md
# Switchable 8/16-bit Stack Unit

This block owns the stack pointer of a small 8-bit processor and sequences every stack memory access. The pointer is 16 bits wide. Its stepping width depends on an extend-disable flag E, which is status bit 5. When E is set, the unit is in 8-bit mode: only the low byte moves and it wraps within its page, while the high byte stays fixed. When E is clear, the unit is in 16-bit mode and the whole pointer carries and borrows.

The core issues one command at a time on `cmd_op`, qualified by `cmd_vld`. The command set is:
- byte push and byte pull;
- a status pull, which hands back the pulled byte with bit 5 replaced by the live E flag, so restoring status never alters the mode;
- a word push;
- a call push, which stores a return address of opcode address + 2, high byte first, and then hands the core a branch target of return address + signed 16-bit offset;
- transfers between the pointer high byte and Y;
- clear-E and set-E.

Memory is reached through a byte-wide port. Reads are combinational and are sampled at the end of the read cycle.

The controller has four states:
- `S_IDLE` accepts commands.
- `S_WR_HI` writes the high byte of a word or call.
- `S_WR_LO` writes a single byte or the low byte.
- `S_RD` reads a pulled byte.

Transitions:
- `S_IDLE`→`S_WR_LO` on a byte push.
- `S_IDLE`→`S_WR_HI` on a word or call push.
- `S_WR_HI`→`S_WR_LO` unconditionally.
- `S_WR_LO`→`S_IDLE` unconditionally.
- `S_IDLE`→`S_RD` on a byte or status pull.
- `S_RD`→`S_IDLE` unconditionally.

All other commands complete in `S_IDLE` within one cycle.

Top module: `stack_seq_unit`

## Requirements
- R1: After reset the pointer reads 0x01FF, E is 1 and `busy` is 0.
- R2: Op 8 clears E and op 9 sets E; the pointer is unchanged by either.
- R3: A byte push (op 1) writes `cmd_data[7:0]` at the current pointer and then steps the pointer down by one.
- R4: A byte pull (op 2) first steps the pointer up by one, then reads at the new pointer; the byte is presented on `pull_data` with a one-cycle `pull_vld` pulse.
- R5: With E=1 the pointer high byte is held and the low byte wraps: a push at 0x0100 leaves 0x01FF, and a pull at 0x01FF leaves 0x0100.
- R6: With E=0 the full 16-bit pointer steps: a pull at 0x01FF gives 0x0200, and a push at 0x0100 gives 0x00FF.
- R7: A word push (op 3) writes `cmd_data[15:8]` at the pointer and `cmd_data[7:0]` one below it, leaving the pointer two lower.
- R8: A call push (op 4) with opcode address `cmd_data` and offset `cmd_ofs` pushes the high byte and then the low byte of `cmd_data`+2. After the last write it pulses `pc_load` with `pc_new` = `cmd_data`+2+`cmd_ofs`.
- R9: A status pull (op 5) behaves as a byte pull, except that bit 5 of `pull_data` equals the current E; E itself does not change.
- R10: Op 6 copies the pointer high byte to `y_out` with a `y_vld` pulse, and sets `flag_n` to its bit 7 and `flag_z` to whether it is zero.
- R11: Op 7 loads `y_in` into the pointer high byte, keeps the low byte, and raises no `y_vld`.
- R12: A command offered while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command valid |
| cmd_op | input | 4 | Command code (0 none, 1 push, 2 pull, 3 word push, 4 call, 5 status pull, 6 pointer to Y, 7 Y to pointer, 8 clear E, 9 set E) |
| cmd_data | input | 16 | Push byte, push word or call opcode address |
| cmd_ofs | input | 16 | Signed call offset |
| y_in | input | 8 | Y register value for op 7 |
| busy | output | 1 | Sequence in progress |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 16 | Stack address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, combinational from `mem_addr` |
| sp_out | output | 16 | Current pointer |
| ext_dis | output | 1 | Flag E (1 = 8-bit mode) |
| pull_vld | output | 1 | Pulled byte valid pulse |
| pull_data | output | 8 | Pulled byte |
| y_vld | output | 1 | Y result valid pulse |
| y_out | output | 8 | Y result |
| flag_n | output | 1 | Negative flag of Y result |
| flag_z | output | 1 | Zero flag of Y result |
| pc_load | output | 1 | Branch target valid pulse |
| pc_new | output | 16 | Branch target |

## Verification
A vector table first walks a byte push/pull round trip in 8-bit mode, then a mode switch, then a word push unwound by two byte pulls. This separates write order and read-back from pointer stepping. Directed sequences then park the pointer at page edges in each mode, which tells a page-wrapping step apart from a carrying or borrowing step. A call with a negative offset checks both the return bytes and the target. Status pulls are done in both modes, so a fixed bit 5 cannot pass. Finally, a command is presented mid-sequence, which would expose a controller that accepts work while busy.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_PUSH   = 4'd1,
        OP_PULL   = 4'd2,
        OP_PUSHW  = 4'd3,
        OP_CALL   = 4'd4,
        OP_PULLST = 4'd5,
        OP_SP2Y   = 4'd6,
        OP_Y2SP   = 4'd7,
        OP_CLRE   = 4'd8,
        OP_SETE   = 4'd9
    } stk_op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WR_HI,
        S_WR_LO,
        S_RD
    } stk_state_e;
endpackage

// File: rtl/stk_ptr_step.sv
module stk_ptr_step #(
    parameter int SP_W = 16,
    parameter int LOW_W = 8
) (
    input  logic [SP_W-1:0] ptr,
    input  logic            narrow,
    output logic [SP_W-1:0] ptr_up,
    output logic [SP_W-1:0] ptr_dn
);
    logic [LOW_W-1:0] low_up, low_dn;

    assign low_up = ptr[LOW_W-1:0] + 1'b1;
    assign low_dn = ptr[LOW_W-1:0] - 1'b1;

    // Narrow mode keeps the page byte; wide mode carries through it.
    assign ptr_up = narrow ? {ptr[SP_W-1:LOW_W], low_up} : ptr + 1'b1;
    assign ptr_dn = narrow ? {ptr[SP_W-1:LOW_W], low_dn} : ptr - 1'b1;
endmodule

// File: rtl/stk_call_calc.sv
module stk_call_calc #(
    parameter int SP_W = 16,
    parameter int RET_STEP = 2
) (
    input  logic [SP_W-1:0] op_addr,
    input  logic [SP_W-1:0] ofs,
    output logic [SP_W-1:0] ret_addr,
    output logic [SP_W-1:0] target
);
    assign ret_addr = op_addr + SP_W'(RET_STEP);
    assign target   = ret_addr + ofs;
endmodule

// File: rtl/stack_seq_unit.sv
module stack_seq_unit #(
    parameter int DATA_W = 8,
    parameter int E_BIT = 5,
    parameter logic [DATA_W-1:0] PAGE_INIT = 8'h01,
    parameter logic [DATA_W-1:0] LOW_INIT = 8'hFF,
    localparam int SP_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  logic [3:0]        cmd_op,
    input  logic [SP_W-1:0]   cmd_data,
    input  logic [SP_W-1:0]   cmd_ofs,
    input  logic [DATA_W-1:0] y_in,
    output logic              busy,
    output logic              mem_we,
    output logic              mem_re,
    output logic [SP_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [SP_W-1:0]   sp_out,
    output logic              ext_dis,
    output logic              pull_vld,
    output logic [DATA_W-1:0] pull_data,
    output logic              y_vld,
    output logic [DATA_W-1:0] y_out,
    output logic              flag_n,
    output logic              flag_z,
    output logic              pc_load,
    output logic [SP_W-1:0]   pc_new
);
    import stk_pkg::*;

    stk_state_e state_q, state_d;
    stk_op_e    op;
    logic [SP_W-1:0]   sp_q, sp_up, sp_dn, ret_addr, target;
    logic [DATA_W-1:0] hi_q, lo_q, rd_fixed;
    logic e_q, call_q, st_q, accept;

    assign op     = stk_op_e'(cmd_op);
    assign accept = cmd_vld && (state_q == S_IDLE);

    stk_ptr_step #(.SP_W(SP_W), .LOW_W(DATA_W)) step_i (
        .ptr(sp_q), .narrow(e_q), .ptr_up(sp_up), .ptr_dn(sp_dn)
    );

    stk_call_calc #(.SP_W(SP_W), .RET_STEP(2)) call_i (
        .op_addr(cmd_data), .ofs(cmd_ofs), .ret_addr(ret_addr), .target(target)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    case (op)
                        OP_PUSH:            state_d = S_WR_LO;
                        OP_PUSHW, OP_CALL:  state_d = S_WR_HI;
                        OP_PULL, OP_PULLST: state_d = S_RD;
                        default:            state_d = S_IDLE;
                    endcase
                end
            end
            S_WR_HI: state_d = S_WR_LO;
            S_WR_LO: state_d = S_IDLE;
            S_RD:    state_d = S_IDLE;
        endcase
    end

    // Memory-side outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        mem_we    = (state_q == S_WR_HI) || (state_q == S_WR_LO);
        mem_re    = (state_q == S_RD);
        mem_addr  = sp_q;
        mem_wdata = (state_q == S_WR_HI) ? hi_q : lo_q;
        rd_fixed  = mem_rdata;
        rd_fixed[E_BIT] = e_q;
    end

    assign sp_out  = sp_q;
    assign ext_dis = e_q;

    // Datapath and registered result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q      <= {PAGE_INIT, LOW_INIT};
            e_q       <= 1'b1;
            hi_q      <= '0;
            lo_q      <= '0;
            call_q    <= 1'b0;
            st_q      <= 1'b0;
            pull_vld  <= 1'b0;
            pull_data <= '0;
            y_vld     <= 1'b0;
            y_out     <= '0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
            pc_load   <= 1'b0;
            pc_new    <= '0;
        end else begin
            pull_vld <= 1'b0;
            y_vld    <= 1'b0;
            pc_load  <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        case (op)
                            OP_PUSH: begin
                                lo_q   <= cmd_data[DATA_W-1:0];
                                call_q <= 1'b0;
                            end
                            OP_PUSHW: begin
                                hi_q   <= cmd_data[SP_W-1:DATA_W];
                                lo_q   <= cmd_data[DATA_W-1:0];
                                call_q <= 1'b0;
                            end
                            OP_CALL: begin
                                hi_q   <= ret_addr[SP_W-1:DATA_W];
                                lo_q   <= ret_addr[DATA_W-1:0];
                                call_q <= 1'b1;
                                pc_new <= target;
                            end
                            OP_PULL: begin
                                sp_q <= sp_up;
                                st_q <= 1'b0;
                            end
                            OP_PULLST: begin
                                sp_q <= sp_up;
                                st_q <= 1'b1;
                            end
                            OP_SP2Y: begin
                                y_out  <= sp_q[SP_W-1:DATA_W];
                                flag_n <= sp_q[SP_W-1];
                                flag_z <= (sp_q[SP_W-1:DATA_W] == '0);
                                y_vld  <= 1'b1;
                            end
                            OP_Y2SP: sp_q[SP_W-1:DATA_W] <= y_in;
                            OP_CLRE: e_q <= 1'b0;
                            OP_SETE: e_q <= 1'b1;
                            default: ;
                        endcase
                    end
                end
                S_WR_HI: sp_q <= sp_dn;
                S_WR_LO: begin
                    sp_q    <= sp_dn;
                    pc_load <= call_q;
                end
                S_RD: begin
                    pull_vld  <= 1'b1;
                    pull_data <= st_q ? rd_fixed : mem_rdata;
                end
            endcase
        end
    end
endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk #(
    parameter int DATA_W = 8,
    localparam int SP_W = 2 * DATA_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_vld,
    input logic            busy,
    input logic            mem_we,
    input logic            mem_re,
    input logic [SP_W-1:0] mem_addr,
    input logic [SP_W-1:0] sp_out,
    input logic            ext_dis,
    input logic            pull_vld,
    input logic            pc_load
);
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re}));

    a_r3_write_at_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == sp_out);

    a_r4_read_at_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> mem_addr == sp_out);

    a_r4_pull_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        pull_vld |-> $past(mem_re));

    a_r5_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ext_dis) |=> sp_out[SP_W-1:DATA_W] == $past(sp_out[SP_W-1:DATA_W]));

    a_r6_full_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !ext_dis) |=> sp_out == $past(sp_out) - SP_W'(1));

    a_r8_target_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> ($past(mem_we) && !busy));

    a_r12_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_vld) |=> $stable(ext_dis));
endmodule

bind stack_seq_unit stk_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .busy(busy),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .sp_out(sp_out), .ext_dis(ext_dis), .pull_vld(pull_vld),
    .pc_load(pc_load)
);

// File: tb/stack_seq_unit_tb_top.sv
`timescale 1ns/1ps
module stack_seq_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_vld = 1'b0;
    logic [3:0] cmd_op = 4'd0;
    logic [15:0] cmd_data = '0, cmd_ofs = '0;
    logic [7:0] y_in = '0;
    logic busy, mem_we, mem_re, ext_dis, pull_vld, y_vld, flag_n, flag_z, pc_load;
    logic [15:0] mem_addr, sp_out, pc_new;
    logic [7:0] mem_wdata, mem_rdata, pull_data, y_out;
    logic [7:0] tb_mem [0:1023];
    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (mem_we) tb_mem[mem_addr[9:0]] <= mem_wdata;
    assign mem_rdata = tb_mem[mem_addr[9:0]];

    stack_seq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_ofs(cmd_ofs), .y_in(y_in), .busy(busy),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sp_out(sp_out),
        .ext_dis(ext_dis), .pull_vld(pull_vld), .pull_data(pull_data),
        .y_vld(y_vld), .y_out(y_out), .flag_n(flag_n), .flag_z(flag_z),
        .pc_load(pc_load), .pc_new(pc_new)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] data;
        logic [7:0]  y;
        logic [15:0] xsp;
        logic        xe;
        logic [7:0]  xpull;
    } vec_t;

    // op codes: 1 push, 2 pull, 3 word push, 7 Y to pointer, 8 clear E, 9 set E
    localparam vec_t TBL [10] = '{
        '{4'd1, 16'h00AA, 8'h00, 16'h01FE, 1'b1, 8'h00},
        '{4'd1, 16'h0055, 8'h00, 16'h01FD, 1'b1, 8'h00},
        '{4'd2, 16'h0000, 8'h00, 16'h01FE, 1'b1, 8'h55},
        '{4'd2, 16'h0000, 8'h00, 16'h01FF, 1'b1, 8'hAA},
        '{4'd7, 16'h0000, 8'h02, 16'h02FF, 1'b1, 8'h00},
        '{4'd8, 16'h0000, 8'h00, 16'h02FF, 1'b0, 8'h00},
        '{4'd3, 16'h1234, 8'h00, 16'h02FD, 1'b0, 8'h00},
        '{4'd2, 16'h0000, 8'h00, 16'h02FE, 1'b0, 8'h34},
        '{4'd2, 16'h0000, 8'h00, 16'h02FF, 1'b0, 8'h12},
        '{4'd9, 16'h0000, 8'h00, 16'h02FF, 1'b1, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [15:0] d,
                       input logic [15:0] o, input logic [7:0] y);
        @(negedge clk);
        cmd_vld = 1'b1; cmd_op = op; cmd_data = d; cmd_ofs = o; y_in = y;
        @(negedge clk);
        cmd_vld = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) tb_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset pointer", sp_out, 16'h01FF);
        chk("R1 reset E", ext_dis, 1'b1);
        chk("R1 reset busy", busy, 1'b0);

        for (int i = 0; i < 10; i++) begin
            run(TBL[i].op, TBL[i].data, 16'h0, TBL[i].y);
            chk($sformatf("R3 R7 R2 table %0d pointer", i), sp_out, TBL[i].xsp);
            chk($sformatf("R2 table %0d E", i), ext_dis, TBL[i].xe);
            if (TBL[i].op == 4'd2) begin
                chk($sformatf("R4 table %0d pull data", i), pull_data, TBL[i].xpull);
                chk($sformatf("R4 table %0d pull valid", i), pull_vld, 1'b1);
            end
        end
        chk("R7 word high byte", tb_mem[10'h2FF], 8'h12);
        chk("R7 word low byte", tb_mem[10'h2FE], 8'h34);

        // R10 / R11 transfers
        run(4'd7, 16'h0, 16'h0, 8'h80);
        chk("R11 Y to pointer", sp_out, 16'h80FF);
        chk("R11 no y_vld", y_vld, 1'b0);
        run(4'd6, 16'h0, 16'h0, 8'h00);
        chk("R10 y_out", y_out, 8'h80);
        chk("R10 flags n,z,vld", {flag_n, flag_z, y_vld}, 3'b101);
        run(4'd7, 16'h0, 16'h0, 8'h00);
        run(4'd6, 16'h0, 16'h0, 8'h00);
        chk("R10 zero flags n,z,vld", {flag_n, flag_z, y_vld}, 3'b011);

        // R5 8-bit wrap
        run(4'd7, 16'h0, 16'h0, 8'h01);
        run(4'd2, 16'h0, 16'h0, 8'h00);
        chk("R5 pull wrap", sp_out, 16'h0100);
        run(4'd1, 16'h005A, 16'h0, 8'h00);
        chk("R5 push wrap", sp_out, 16'h01FF);
        chk("R5 push wrap data", tb_mem[10'h100], 8'h5A);

        // R6 16-bit carry and borrow
        run(4'd8, 16'h0, 16'h0, 8'h00);
        chk("R2 clear keeps pointer", sp_out, 16'h01FF);
        run(4'd2, 16'h0, 16'h0, 8'h00);
        chk("R6 pull carry", sp_out, 16'h0200);
        run(4'd1, 16'h0077, 16'h0, 8'h00);
        run(4'd7, 16'h0, 16'h0, 8'h00);
        run(4'd2, 16'h0, 16'h0, 8'h00);
        chk("R6 pull to 0100", sp_out, 16'h0100);
        chk("R4 R6 pull data", pull_data, 8'h5A);
        run(4'd1, 16'h0066, 16'h0, 8'h00);
        chk("R6 push borrow", sp_out, 16'h00FF);
        chk("R6 push borrow data", tb_mem[10'h100], 8'h66);

        // R8 call push
        run(4'd7, 16'h0, 16'h0, 8'h03);
        run(4'd4, 16'h1230, 16'hFFF0, 8'h00);
        chk("R8 target pulse", pc_load, 1'b1);
        chk("R8 target", pc_new, 16'h1222);
        chk("R8 return high", tb_mem[10'h3FF], 8'h12);
        chk("R8 return low", tb_mem[10'h3FE], 8'h32);
        chk("R8 pointer", sp_out, 16'h03FD);

        // R9 status pull
        run(4'd1, 16'h00FF, 16'h0, 8'h00);
        run(4'd5, 16'h0, 16'h0, 8'h00);
        chk("R9 bit5 follows E=0", pull_data, 8'hDF);
        chk("R9 E kept 0", ext_dis, 1'b0);
        run(4'd9, 16'h0, 16'h0, 8'h00);
        run(4'd1, 16'h0000, 16'h0, 8'h00);
        run(4'd5, 16'h0, 16'h0, 8'h00);
        chk("R9 bit5 follows E=1", pull_data, 8'h20);
        chk("R9 E kept 1", ext_dis, 1'b1);

        // R12 command while busy
        run(4'd8, 16'h0, 16'h0, 8'h00);
        @(negedge clk);
        cmd_vld = 1'b1; cmd_op = 4'd3; cmd_data = 16'hBEEF;
        @(negedge clk);
        cmd_op = 4'd9;
        @(negedge clk);
        cmd_vld = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R12 E unchanged", ext_dis, 1'b0);
        chk("R12 pointer", sp_out, 16'h03FB);
        chk("R12 R7 high", tb_mem[10'h3FD], 8'hBE);
        chk("R12 R7 low", tb_mem[10'h3FC], 8'hEF);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule